// File: doc/BRIEF.md
# Instruction Decode Stage

This block turns one 32-bit instruction word into the fields and control strobes that the rest of a small load/store processor needs. The word holds a 4-bit primary opcode in bits 31:28 and three 4-bit register fields: destination in 27:24, first source in 23:20 and second source in 19:16. A 16-bit immediate sits in bits 15:0. A secondary operation code picks the exact operation within a family. Where that code is found depends on the family: the low immediate bits for register-register forms, the destination field for store and branch, and the second-source field for immediate, load and jump forms.

The decoder produces the sign-extended immediate, the secondary code, the register numbers, an instruction class and the control strobes: register write and its target, memory read, memory write, branch, jump, and whether the immediate or the second register feeds the ALU. Any encoding that is not defined raises an illegal flag and suppresses every side effect. All results are registered once, so they appear one clock after the word is presented.

Top module: `instr_decode_stage`

## Requirements
- R1: While reset is low, and on the first edge after it, every output is zero. Class 0 means no instruction.
- R2: One clock after a word is applied, `rs_o` holds bits 23:20 and `rt_o` holds bits 19:16. `rd_o` holds bits 27:24 when the instruction writes a register.
- R3: `imm_o` is bits 15:0 sign-extended to DATA_W bits, for every word.
- R4: The secondary code `op2_o` is taken from bits 3:0 for primary codes 0000 and 0010. It is taken from bits 27:24 for 0101 and 0110, and from bits 19:16 for 1000, 1010, 1001 and 1011.
- R5: For primary codes 0000 and 0010, any nonzero bit in 15:4 makes the word illegal.
- R6: The primary codes map to classes as follows. 0000 and 1000 are ALU (class 1). 0010 and 1010 are compare (class 2). 1001 is load (class 3). 0101 is store (class 4). 0110 is branch (class 5). 1011 is jump-and-link (class 6). Every other primary code is illegal.
- R7: ALU secondary codes 0000, 0001, 0100, 0101, 0110, 1100, 1101 and 1110 are legal in both ALU forms. Code 1011 (move-high) is legal only with primary code 1000. All other ALU codes are illegal.
- R8: For compare and branch, every secondary code is legal except 0100 and 1100.
- R9: Load, store and jump-and-link accept only secondary code 0000.
- R10: Register write is set for the ALU, compare, load and jump classes. Memory read is set only for load, memory write only for store, branch only for branch, and jump only for jump-and-link.
- R11: `use_imm_o` is set for primary codes 1000, 1010, 1001, 0101 and 1011, and is clear for all others.
- R12: An illegal word sets `illegal_o`. It forces class 0 and zero on every strobe, on `rd_o` and on `op2_o`.
- R13: When register write is clear, `rd_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_i | input | 32 | Instruction word to decode |
| class_o | output | 3 | Instruction class |
| rd_o | output | 4 | Destination register, 0 when no write |
| rs_o | output | 4 | First source register |
| rt_o | output | 4 | Second source register field |
| op2_o | output | 4 | Secondary operation code |
| imm_o | output | DATA_W | Sign-extended immediate |
| reg_we_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| branch_o | output | 1 | Conditional branch |
| jump_o | output | 1 | Jump-and-link |
| use_imm_o | output | 1 | ALU second operand is the immediate |
| illegal_o | output | 1 | Undefined encoding |

## Verification
Every result passes through a single output register, so it is due exactly one rising edge after the word is applied. The bench drives a word on a falling edge and samples on the next falling edge. That sample point lies after the one register stage and before the next word can reach the outputs. Because each word is checked before the following one is applied, an illegal word is also shown to leave no strobe behind it. The reset value is sampled on a falling edge while reset is still low.

// File: rtl/rid_pkg.sv
package rid_pkg;
    localparam int INSN_W = 32;
    localparam int OPC_W  = 4;
    localparam int REG_W  = 4;
    localparam int IMM_W  = 16;

    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_ALU    = 3'd1,
        CLS_CMP    = 3'd2,
        CLS_LOAD   = 3'd3,
        CLS_STORE  = 3'd4,
        CLS_BRANCH = 3'd5,
        CLS_JUMP   = 3'd6
    } cls_e;

    // where the secondary code lives
    typedef enum logic [1:0] {
        SEL_LOW  = 2'd0,
        SEL_DEST = 2'd1,
        SEL_SRC2 = 2'd2
    } op2_sel_e;

    typedef struct packed {
        cls_e             cls;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] op2;
        logic             reg_we;
        logic             mem_rd;
        logic             mem_wr;
        logic             branch;
        logic             jump;
        logic             use_imm;
        logic             illegal;
    } ctl_t;
endpackage

// File: rtl/rid_fields.sv
module rid_fields
    import rid_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output logic [OPC_W-1:0]  op1_o,
    output logic [REG_W-1:0]  rd_o,
    output logic [REG_W-1:0]  rs_o,
    output logic [REG_W-1:0]  rt_o,
    output logic [IMM_W-1:0]  imm_o,
    output logic [REG_W-1:0]  op2_o,
    output logic              pad_zero_o
);
    localparam int OP1_LO = INSN_W - OPC_W;
    localparam int RD_LO  = OP1_LO - REG_W;
    localparam int RS_LO  = RD_LO - REG_W;
    localparam int RT_LO  = RS_LO - REG_W;

    op2_sel_e sel;

    always_comb begin
        op1_o      = insn_i[INSN_W-1 -: OPC_W];
        rd_o       = insn_i[RD_LO +: REG_W];
        rs_o       = insn_i[RS_LO +: REG_W];
        rt_o       = insn_i[RT_LO +: REG_W];
        imm_o      = insn_i[IMM_W-1:0];
        pad_zero_o = (insn_i[IMM_W-1:REG_W] == '0);

        // immediate-style families all have the top opcode bit set
        if (op1_o[OPC_W-1])
            sel = SEL_SRC2;
        else if (op1_o == 4'b0101 || op1_o == 4'b0110)
            sel = SEL_DEST;
        else
            sel = SEL_LOW;

        case (sel)
            SEL_DEST: op2_o = rd_o;
            SEL_SRC2: op2_o = rt_o;
            default:  op2_o = insn_i[REG_W-1:0];
        endcase
    end
endmodule

// File: rtl/rid_legal.sv
module rid_legal
    import rid_pkg::*;
(
    input  logic [OPC_W-1:0] op1_i,
    input  logic [REG_W-1:0] op2_i,
    input  logic             pad_zero_i,
    output cls_e             cls_o,
    output logic             legal_o
);
    cls_e raw_cls;
    logic raw_ok;
    logic alu_reg_ok;
    logic alu_imm_ok;
    logic cmp_ok;

    always_comb begin
        case (op2_i)
            4'b0000, 4'b0001, 4'b0100, 4'b0101,
            4'b0110, 4'b1100, 4'b1101, 4'b1110: begin
                alu_reg_ok = 1'b1;
                alu_imm_ok = 1'b1;
            end
            4'b1011: begin
                alu_reg_ok = 1'b0;
                alu_imm_ok = 1'b1;
            end
            default: begin
                alu_reg_ok = 1'b0;
                alu_imm_ok = 1'b0;
            end
        endcase

        cmp_ok = (op2_i[2:0] != 3'b100);

        case (op1_i)
            4'b0000: begin raw_cls = CLS_ALU;    raw_ok = pad_zero_i && alu_reg_ok; end
            4'b1000: begin raw_cls = CLS_ALU;    raw_ok = alu_imm_ok;               end
            4'b0010: begin raw_cls = CLS_CMP;    raw_ok = pad_zero_i && cmp_ok;     end
            4'b1010: begin raw_cls = CLS_CMP;    raw_ok = cmp_ok;                   end
            4'b0110: begin raw_cls = CLS_BRANCH; raw_ok = cmp_ok;                   end
            4'b1001: begin raw_cls = CLS_LOAD;   raw_ok = (op2_i == '0);            end
            4'b0101: begin raw_cls = CLS_STORE;  raw_ok = (op2_i == '0);            end
            4'b1011: begin raw_cls = CLS_JUMP;   raw_ok = (op2_i == '0);            end
            default: begin raw_cls = CLS_NONE;   raw_ok = 1'b0;                     end
        endcase

        legal_o = raw_ok;
        cls_o   = raw_ok ? raw_cls : CLS_NONE;
    end

    // R12
    always_comb begin
        cls_legal_chk: assert (legal_o == (cls_o != CLS_NONE));
    end
endmodule

// File: rtl/rid_ctrl.sv
module rid_ctrl
    import rid_pkg::*;
(
    input  cls_e             cls_i,
    input  logic             legal_i,
    input  logic [OPC_W-1:0] op1_i,
    input  logic [REG_W-1:0] rd_i,
    input  logic [REG_W-1:0] rs_i,
    input  logic [REG_W-1:0] rt_i,
    input  logic [REG_W-1:0] op2_i,
    output ctl_t             ctl_o
);
    always_comb begin
        ctl_o         = '0;
        ctl_o.cls     = cls_i;
        ctl_o.rs      = rs_i;
        ctl_o.rt      = rt_i;
        ctl_o.illegal = !legal_i;
        ctl_o.op2     = legal_i ? op2_i : '0;
        ctl_o.reg_we  = (cls_i == CLS_ALU) || (cls_i == CLS_CMP) ||
                        (cls_i == CLS_LOAD) || (cls_i == CLS_JUMP);
        ctl_o.rd      = ctl_o.reg_we ? rd_i : '0;
        ctl_o.mem_rd  = (cls_i == CLS_LOAD);
        ctl_o.mem_wr  = (cls_i == CLS_STORE);
        ctl_o.branch  = (cls_i == CLS_BRANCH);
        ctl_o.jump    = (cls_i == CLS_JUMP);
        // store needs the immediate for its address even though op1[3] is 0
        ctl_o.use_imm = legal_i && (op1_i[OPC_W-1] || cls_i == CLS_STORE);
    end
endmodule

// File: rtl/instr_decode_stage.sv
module instr_decode_stage
    import rid_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       insn_i,
    output logic [2:0]        class_o,
    output logic [3:0]        rd_o,
    output logic [3:0]        rs_o,
    output logic [3:0]        rt_o,
    output logic [3:0]        op2_o,
    output logic [DATA_W-1:0] imm_o,
    output logic              reg_we_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              branch_o,
    output logic              jump_o,
    output logic              use_imm_o,
    output logic              illegal_o
);
    localparam int EXT_W = DATA_W - IMM_W;

    typedef struct packed {
        ctl_t              ctl;
        logic [DATA_W-1:0] imm;
    } dec_t;

    logic [OPC_W-1:0] f_op1;
    logic [REG_W-1:0] f_rd, f_rs, f_rt, f_op2;
    logic [IMM_W-1:0] f_imm;
    logic             f_pad_zero;
    cls_e             l_cls;
    logic             l_legal;
    ctl_t             c_ctl;
    dec_t             dec_d, dec_q;

    rid_fields u_fields (
        .insn_i     (insn_i),
        .op1_o      (f_op1),
        .rd_o       (f_rd),
        .rs_o       (f_rs),
        .rt_o       (f_rt),
        .imm_o      (f_imm),
        .op2_o      (f_op2),
        .pad_zero_o (f_pad_zero)
    );

    rid_legal u_legal (
        .op1_i      (f_op1),
        .op2_i      (f_op2),
        .pad_zero_i (f_pad_zero),
        .cls_o      (l_cls),
        .legal_o    (l_legal)
    );

    rid_ctrl u_ctrl (
        .cls_i   (l_cls),
        .legal_i (l_legal),
        .op1_i   (f_op1),
        .rd_i    (f_rd),
        .rs_i    (f_rs),
        .rt_i    (f_rt),
        .op2_i   (f_op2),
        .ctl_o   (c_ctl)
    );

    always_comb begin
        dec_d.ctl = c_ctl;
        dec_d.imm = {{EXT_W{f_imm[IMM_W-1]}}, f_imm};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dec_q <= '0;
        else
            dec_q <= dec_d;
    end

    assign class_o   = dec_q.ctl.cls;
    assign rd_o      = dec_q.ctl.rd;
    assign rs_o      = dec_q.ctl.rs;
    assign rt_o      = dec_q.ctl.rt;
    assign op2_o     = dec_q.ctl.op2;
    assign imm_o     = dec_q.imm;
    assign reg_we_o  = dec_q.ctl.reg_we;
    assign mem_rd_o  = dec_q.ctl.mem_rd;
    assign mem_wr_o  = dec_q.ctl.mem_wr;
    assign branch_o  = dec_q.ctl.branch;
    assign jump_o    = dec_q.ctl.jump;
    assign use_imm_o = dec_q.ctl.use_imm;
    assign illegal_o = dec_q.ctl.illegal;

    // R12
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !(reg_we_o || mem_rd_o || mem_wr_o || branch_o || jump_o) && class_o == 3'd0);

    // R10
    one_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, mem_wr_o, branch_o, jump_o}));

    // R10
    jal_links_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |-> reg_we_o && use_imm_o);

    // R13
    nowrite_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we_o |-> rd_o == 4'd0);

    // R4
    store_op2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> op2_o == $past(insn_i[27:24]) && rt_o == $past(insn_i[19:16]));

    // R5
    pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!illegal_o && !use_imm_o && (class_o == 3'd1 || class_o == 3'd2))
            |-> $past(insn_i[15:4]) == 12'd0);
endmodule

// File: tb/instr_decode_stage_test.sv
`timescale 1ns/1ps
module instr_decode_stage_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn_i = 32'hFFFF_FFFF;
    logic [2:0]  class_o;
    logic [3:0]  rd_o, rs_o, rt_o, op2_o;
    logic [31:0] imm_o;
    logic        reg_we_o, mem_rd_o, mem_wr_o, branch_o, jump_o, use_imm_o, illegal_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    instr_decode_stage uut (
        .clk(clk), .rst_n(rst_n), .insn_i(insn_i),
        .class_o(class_o), .rd_o(rd_o), .rs_o(rs_o), .rt_o(rt_o),
        .op2_o(op2_o), .imm_o(imm_o), .reg_we_o(reg_we_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .branch_o(branch_o),
        .jump_o(jump_o), .use_imm_o(use_imm_o), .illegal_o(illegal_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // apply on a falling edge, sample one rising edge later on the next falling edge
    task automatic apply(logic [3:0] op1, logic [3:0] a, logic [3:0] b, logic [3:0] c, logic [15:0] imm);
        insn_i = {op1, a, b, c, imm};
        @(negedge clk);
    endtask

    // flags packed as {we, mem_rd, mem_wr, branch, jump, use_imm, illegal}
    task automatic expect_ctl(string req, logic [2:0] cls, logic [6:0] flags, logic [3:0] rd, logic [3:0] op2);
        check({req, " class"}, {29'd0, class_o}, {29'd0, cls});
        check({req, " flags"}, {25'd0, reg_we_o, mem_rd_o, mem_wr_o, branch_o, jump_o, use_imm_o, illegal_o},
              {25'd0, flags});
        check({req, " rd"}, {28'd0, rd_o}, {28'd0, rd});
        check({req, " op2"}, {28'd0, op2_o}, {28'd0, op2});
    endtask

    task automatic t_reset;
        @(negedge clk);
        // R1
        expect_ctl("R1", 3'd0, 7'b0000000, 4'd0, 4'd0);
        check("R1 imm", imm_o, 32'd0);
        check("R1 rs", {28'd0, rs_o}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_alu;
        apply(4'h0, 4'h3, 4'h1, 4'h2, 16'h0000);
        expect_ctl("R10 alur add", 3'd1, 7'b1000000, 4'h3, 4'h0);
        check("R2 rs", {28'd0, rs_o}, 32'h1);
        check("R2 rt", {28'd0, rt_o}, 32'h2);
        apply(4'h0, 4'h4, 4'h5, 4'h6, 16'h000E);
        expect_ctl("R7 alur nxor", 3'd1, 7'b1000000, 4'h4, 4'hE);
        apply(4'h0, 4'h4, 4'h5, 4'h6, 16'h000B);
        expect_ctl("R7 alur move-high", 3'd0, 7'b0000001, 4'h0, 4'h0);
        apply(4'h0, 4'h4, 4'h5, 4'h6, 16'h0010);
        expect_ctl("R5 alur pad", 3'd0, 7'b0000001, 4'h0, 4'h0);
        apply(4'h8, 4'h5, 4'h2, 4'hB, 16'h8001);
        expect_ctl("R11 alui move-high", 3'd1, 7'b1000010, 4'h5, 4'hB);
        check("R3 imm neg", imm_o, 32'hFFFF_8001);
        apply(4'h8, 4'h5, 4'h2, 4'h3, 16'h0001);
        expect_ctl("R7 alui bad", 3'd0, 7'b0000001, 4'h0, 4'h0);
    endtask

    task automatic t_cmp;
        apply(4'hA, 4'h7, 4'h4, 4'h2, 16'h0005);
        expect_ctl("R4 cmpi lt", 3'd2, 7'b1000010, 4'h7, 4'h2);
        check("R3 imm pos", imm_o, 32'h0000_0005);
        apply(4'h2, 4'h9, 4'h1, 4'h2, 16'h000B);
        expect_ctl("R8 cmpr gt", 3'd2, 7'b1000000, 4'h9, 4'hB);
        apply(4'h2, 4'h9, 4'h1, 4'h2, 16'h0004);
        expect_ctl("R8 cmpr hole", 3'd0, 7'b0000001, 4'h0, 4'h0);
        apply(4'h2, 4'h9, 4'h1, 4'h2, 16'h8001);
        expect_ctl("R5 cmpr pad", 3'd0, 7'b0000001, 4'h0, 4'h0);
    endtask

    task automatic t_branch;
        apply(4'h6, 4'h9, 4'h3, 4'h4, 16'hFFFE);
        expect_ctl("R13 bcond ne", 3'd5, 7'b0001000, 4'h0, 4'h9);
        check("R3 branch imm", imm_o, 32'hFFFF_FFFE);
        check("R2 branch rt", {28'd0, rt_o}, 32'h4);
        apply(4'h6, 4'hC, 4'h3, 4'h4, 16'h0002);
        expect_ctl("R8 bcond hole", 3'd0, 7'b0000001, 4'h0, 4'h0);
    endtask

    task automatic t_mem;
        apply(4'h9, 4'h2, 4'hE, 4'h0, 16'h0010);
        expect_ctl("R10 load", 3'd3, 7'b1100010, 4'h2, 4'h0);
        apply(4'h9, 4'h2, 4'hE, 4'h1, 16'h0010);
        expect_ctl("R9 load op2", 3'd0, 7'b0000001, 4'h0, 4'h0);
        apply(4'h5, 4'h0, 4'hE, 4'h6, 16'hFFFC);
        expect_ctl("R11 store", 3'd4, 7'b0010010, 4'h0, 4'h0);
        check("R2 store rt", {28'd0, rt_o}, 32'h6);
        apply(4'h5, 4'h2, 4'hE, 4'h6, 16'hFFFC);
        expect_ctl("R9 store op2", 3'd0, 7'b0000001, 4'h0, 4'h0);
    endtask

    task automatic t_jal;
        apply(4'hB, 4'hF, 4'h1, 4'h0, 16'h0003);
        expect_ctl("R10 jal", 3'd6, 7'b1000110, 4'hF, 4'h0);
        apply(4'hB, 4'hF, 4'h1, 4'h2, 16'h0003);
        expect_ctl("R9 jal op2", 3'd0, 7'b0000001, 4'h0, 4'h0);
    endtask

    task automatic t_bad_op1;
        for (int k = 0; k < 16; k++) begin
            logic [3:0] op = 4'(k);
            if (op == 4'h0 || op == 4'h8 || op == 4'h2 || op == 4'hA ||
                op == 4'h6 || op == 4'h5 || op == 4'h9 || op == 4'hB) continue;
            apply(op, 4'h1, 4'h2, 4'h0, 16'h0000);
            // R6
            expect_ctl("R6 undefined op1", 3'd0, 7'b0000001, 4'h0, 4'h0);
            // R12
            check("R12 no imm select", {31'd0, use_imm_o}, 32'd0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_alu();
        t_cmp();
        t_branch();
        t_mem();
        t_jal();
        t_bad_op1();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule